// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block supervises the recovery of a CAN controller from the bus-off condition. A bus-off trigger from the error-counting logic puts the block into bus-off. At the same time it forces the initialization flag high, and that flag holds the controller off the bus. Recovery does not start until software writes the initialization flag back to zero. The block then watches the received bit on each bit-sample strobe. It counts runs of 11 consecutive recessive bits, and it needs 129 such runs before the controller may rejoin the bus.

Software can follow the wait through a 3-bit last-error-code field. Every completed idle run writes the bit-0 error code into that field. If the code never appears, the bus is stuck dominant. If it appears only now and then, the bus is being disturbed. At the end of the wait the block clears its bus-off status and raises a one-cycle recovery-done pulse. In the same cycle it raises a one-cycle pulse that tells the error counters to return to zero. The block also holds the small control register that sits alongside: the initialization flag, a retransmission-disable bit, a configuration-change-enable bit, a test-mode bit and the bit-timing register, which is write-protected.

Top module: `boff_recovery_seq`

## Requirements
- R1: After reset: init_flag=1, busoff=0, lec=3'b000, retx_off=0, cfg_change_en=0, test_mode=0, rec_done=0, cnt_clr=0, and bt_value equals the reset parameter (default 32'h0000_2301).
- R2: A write to address 0 (control) loads init_flag from data bit 0, retx_off from bit 5, cfg_change_en from bit 6 and test_mode from bit 7. All other data bits have no effect.
- R3: A write to address 2 (bit timing) loads bt_value with the data ANDed with the mask (default 32'h0000_7FFF). The write is accepted only when init_flag and cfg_change_en are both 1 before the write; otherwise bt_value is unchanged.
- R4: When busoff_evt is sampled high while busoff=0, busoff and init_flag are both 1 on the next cycle.
- R5: While bus-off with init_flag still 1, recessive bits are not counted: lec does not change and no recovery completes.
- R6: After software clears init_flag during bus-off, each strobe with rx_bit=1 extends the current run. The 11th consecutive recessive bit completes a run and sets lec to 3'b101 on the next cycle. A strobe with rx_bit=0 restarts the run without changing the number of completed runs.
- R7: The strobe that completes the 129th run ends recovery. On the next cycle busoff=0, and rec_done and cnt_clr are both 1.
- R8: A write to address 1 (status) loads lec from data bits 2:0, except that 3'b111 leaves lec unchanged. A run completing in the same cycle takes priority over the write.
- R9: rec_done and cnt_clr last exactly one cycle and occur only at the end of a recovery.
- R10: Writing init_flag to 1 and back to 0 during the recovery wait neither restarts nor shortens it.
- R11: rx_bit is ignored on cycles where bit_strobe is low.
- R12: A busoff_evt while busoff=1 has no effect on the recovery in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_strobe | input | 1 | High for one cycle at each bit sample point |
| rx_bit | input | 1 | Received bus level (1 = recessive) |
| busoff_evt | input | 1 | Bus-off trigger from the error counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 status, 2 bit timing |
| wr_data | input | 32 | Register write data |
| init_flag | output | 1 | Initialization flag; holds the controller off the bus |
| retx_off | output | 1 | Automatic retransmission disabled |
| cfg_change_en | output | 1 | Bit-timing write enable (used together with init_flag) |
| test_mode | output | 1 | Test mode enabled |
| bt_value | output | 32 | Bit-timing register contents |
| lec | output | 3 | Last-error-code field |
| busoff | output | 1 | Bus-off status |
| rec_done | output | 1 | One-cycle pulse at the end of recovery |
| cnt_clr | output | 1 | One-cycle pulse that clears the error counters |

## Verification
An error in the run or occurrence counters shows up at the ports quickly. A run counter that is off by one moves the first bit-0 code in lec by one strobe. A counter that ignores the strobe gate or a dominant bit moves it by several strobes. Any error in the occurrence count moves rec_done away from the exact 1419th recessive strobe after the dominant bit. So the bench checks the strobe after which each pulse must appear, and also checks that no pulse appears on any strobe before it. A phase register stuck in the wrong state shows immediately: either busoff or init_flag fails to follow the trigger, or lec changes while init_flag is still held.

// File: rtl/boff_pkg.sv
// Package: shared types and constants for the bus-off recovery sequencer.
// Assumes: register addresses are 2 bits; the last-error code field is 3 bits.
package boff_pkg;

    // Recovery phase of the sequencer
    typedef enum logic [1:0] {
        PH_ACTIVE  = 2'b00,  // taking part on the bus
        PH_HELD    = 2'b01,  // bus-off, waiting for software to drop init
        PH_RECOVER = 2'b10   // counting idle runs
    } boff_phase_t;

    localparam int LEC_W = 3;
    localparam logic [LEC_W-1:0] LEC_BIT0 = 3'b101;
    localparam logic [LEC_W-1:0] LEC_KEEP = 3'b111;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_BT   = 2'd2;

    // Bit positions inside the control word
    localparam int CTRL_INIT = 0;
    localparam int CTRL_DAR  = 5;
    localparam int CTRL_CCE  = 6;
    localparam int CTRL_TEST = 7;

endpackage

// File: rtl/boff_idle_counter.sv
// Module: counts runs of recessive bits and completed idle runs.
// Does: while count_en is high, on each strobe it grows the run with a
// recessive bit or restarts it with a dominant one. A full run bumps the
// occurrence count. seq_done marks the strobe that completes the last run.
// Assumes: RUN_W holds RUN_LEN-1 and OCC_W holds IDLE_COUNT-1.
module boff_idle_counter #(
    parameter int RUN_LEN    = 11,
    parameter int IDLE_COUNT = 129,
    parameter int RUN_W      = 4,
    parameter int OCC_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             clear,
    input  logic             strobe,
    input  logic             rx_bit,
    output logic             run_done,
    output logic             seq_done,
    output logic [RUN_W-1:0] run_cnt,
    output logic [OCC_W-1:0] occ_cnt
);

    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(IDLE_COUNT - 1);

    logic sample;

    // Purpose: qualify the bus sample with the strobe and the enable
    always_comb begin
        sample   = count_en & strobe;
        run_done = sample & rx_bit & (run_cnt == RUN_LAST);
        seq_done = run_done & (occ_cnt == OCC_LAST);
    end

    // Purpose: length of the current recessive run
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_cnt <= '0;
        end else if (sample) begin
            if (!rx_bit || run_done) begin
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Purpose: number of completed idle runs
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            occ_cnt <= '0;
        end else if (run_done) begin
            if (seq_done) begin
                occ_cnt <= '0;
            end else begin
                occ_cnt <= occ_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/boff_phase_fsm.sv
// Module: bus-off phase controller.
// Does: enters bus-off on the trigger, waits for software to clear the init
// flag, then lets the counter run until the final idle run is done. At the
// end it raises the done and counter-clear pulses for one cycle.
// Assumes: seq_done can be high only in PH_RECOVER.
module boff_phase_fsm
    import boff_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busoff_evt,
    input  logic        init_q,
    input  logic        seq_done,
    output boff_phase_t phase,
    output logic        set_init,
    output logic        count_en,
    output logic        cnt_clear,
    output logic        busoff,
    output logic        rec_done,
    output logic        cnt_clr
);

    boff_phase_t phase_nx;

    // Purpose: next-phase decision
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_ACTIVE:  if (busoff_evt) phase_nx = PH_HELD;
            PH_HELD:    if (!init_q)    phase_nx = PH_RECOVER;
            PH_RECOVER: if (seq_done)   phase_nx = PH_ACTIVE;
            default:                    phase_nx = PH_ACTIVE;
        endcase
    end

    // Purpose: controls handed to the register file and the counter
    always_comb begin
        set_init  = (phase == PH_ACTIVE) && busoff_evt;
        count_en  = (phase == PH_RECOVER);
        cnt_clear = (phase != PH_RECOVER);
    end

    // Purpose: phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_ACTIVE;
        end else begin
            phase <= phase_nx;
        end
    end

    // Purpose: bus-off status flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busoff <= 1'b0;
        end else if (set_init) begin
            busoff <= 1'b1;
        end else if (seq_done) begin
            busoff <= 1'b0;
        end
    end

    // Purpose: single-cycle completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_done <= 1'b0;
            cnt_clr  <= 1'b0;
        end else begin
            rec_done <= seq_done;
            cnt_clr  <= seq_done;
        end
    end

endmodule

// File: rtl/boff_ctrl_regs.sv
// Module: software-visible control, status and bit-timing registers.
// Does: decodes register writes. Bus-off entry forces the init flag high.
// The bit-timing register is protected by init and config-enable. A
// completed run writes the bit-0 code into lec, ahead of any software write.
// Assumes: one write per cycle; bit positions come from boff_pkg.
module boff_ctrl_regs
    import boff_pkg::*;
#(
    parameter int               DATA_W  = 32,
    parameter logic [DATA_W-1:0] BT_RST  = 32'h0000_2301,
    parameter logic [DATA_W-1:0] BT_MASK = 32'h0000_7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_init,
    input  logic              lec_hw_set,
    output logic              init_flag,
    output logic              retx_off,
    output logic              cfg_change_en,
    output logic              test_mode,
    output logic [DATA_W-1:0] bt_value,
    output logic [LEC_W-1:0]  lec
);

    logic wr_ctrl, wr_stat, wr_bt, bt_open;

    // Purpose: address decode and bit-timing protection
    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        wr_stat = wr_en && (wr_addr == ADDR_STAT);
        wr_bt   = wr_en && (wr_addr == ADDR_BT);
        bt_open = init_flag && cfg_change_en;
    end

    // Purpose: init flag, forced by bus-off entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_flag <= 1'b1;
        end else if (set_init) begin
            init_flag <= 1'b1;
        end else if (wr_ctrl) begin
            init_flag <= wr_data[CTRL_INIT];
        end
    end

    // Purpose: remaining control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retx_off      <= 1'b0;
            cfg_change_en <= 1'b0;
            test_mode     <= 1'b0;
        end else if (wr_ctrl) begin
            retx_off      <= wr_data[CTRL_DAR];
            cfg_change_en <= wr_data[CTRL_CCE];
            test_mode     <= wr_data[CTRL_TEST];
        end
    end

    // Purpose: protected bit-timing register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bt_value <= BT_RST;
        end else if (wr_bt && bt_open) begin
            bt_value <= wr_data & BT_MASK;
        end
    end

    // Purpose: last-error-code field, hardware code first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lec <= '0;
        end else if (lec_hw_set) begin
            lec <= LEC_BIT0;
        end else if (wr_stat && (wr_data[LEC_W-1:0] != LEC_KEEP)) begin
            lec <= wr_data[LEC_W-1:0];
        end
    end

endmodule

// File: rtl/boff_recovery_seq.sv
// Module: top of the CAN bus-off recovery sequencer.
// Does: ties the register file, the phase controller and the idle-run
// counter together. Bus timing and framing sit outside this block.
// Assumes: bit_strobe is high for one cycle per bit; rx_bit is valid with it.
module boff_recovery_seq
    import boff_pkg::*;
#(
    parameter int               RUN_LEN    = 11,
    parameter int               IDLE_COUNT = 129,
    parameter int               RUN_W      = 4,
    parameter int               OCC_W      = 8,
    parameter int               DATA_W     = 32,
    parameter logic [DATA_W-1:0] BT_RST    = 32'h0000_2301,
    parameter logic [DATA_W-1:0] BT_MASK   = 32'h0000_7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_strobe,
    input  logic              rx_bit,
    input  logic              busoff_evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              init_flag,
    output logic              retx_off,
    output logic              cfg_change_en,
    output logic              test_mode,
    output logic [DATA_W-1:0] bt_value,
    output logic [LEC_W-1:0]  lec,
    output logic              busoff,
    output logic              rec_done,
    output logic              cnt_clr
);

    boff_phase_t      phase;
    logic             set_init, count_en, cnt_clear;
    logic             run_done, seq_done;
    logic [RUN_W-1:0] run_cnt;
    logic [OCC_W-1:0] occ_cnt;

    boff_ctrl_regs #(
        .DATA_W (DATA_W),
        .BT_RST (BT_RST),
        .BT_MASK(BT_MASK)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .set_init     (set_init),
        .lec_hw_set   (run_done),
        .init_flag    (init_flag),
        .retx_off     (retx_off),
        .cfg_change_en(cfg_change_en),
        .test_mode    (test_mode),
        .bt_value     (bt_value),
        .lec          (lec)
    );

    boff_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .busoff_evt(busoff_evt),
        .init_q    (init_flag),
        .seq_done  (seq_done),
        .phase     (phase),
        .set_init  (set_init),
        .count_en  (count_en),
        .cnt_clear (cnt_clear),
        .busoff    (busoff),
        .rec_done  (rec_done),
        .cnt_clr   (cnt_clr)
    );

    boff_idle_counter #(
        .RUN_LEN   (RUN_LEN),
        .IDLE_COUNT(IDLE_COUNT),
        .RUN_W     (RUN_W),
        .OCC_W     (OCC_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(count_en),
        .clear   (cnt_clear),
        .strobe  (bit_strobe),
        .rx_bit  (rx_bit),
        .run_done(run_done),
        .seq_done(seq_done),
        .run_cnt (run_cnt),
        .occ_cnt (occ_cnt)
    );

endmodule

// File: rtl/boff_recovery_chk.sv
// Module: assertion checker bound into boff_recovery_seq.
// Does: checks temporal rules on the ports and on the counter state.
// Assumes: reset is held for at least one clock at start-up.
module boff_recovery_chk
    import boff_pkg::*;
#(
    parameter int RUN_LEN    = 11,
    parameter int IDLE_COUNT = 129,
    parameter int RUN_W      = 4,
    parameter int OCC_W      = 8,
    parameter int DATA_W     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_strobe,
    input logic              busoff_evt,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              init_flag,
    input logic              cfg_change_en,
    input logic [DATA_W-1:0] bt_value,
    input logic [LEC_W-1:0]  lec,
    input logic              busoff,
    input logic              rec_done,
    input logic              cnt_clr,
    input boff_phase_t       phase,
    input logic [RUN_W-1:0]  run_cnt,
    input logic [OCC_W-1:0]  occ_cnt
);

    AST_BT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_flag && cfg_change_en) |=> $stable(bt_value)); // R3

    AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_evt && !busoff) |=> (busoff && init_flag)); // R4

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < RUN_W'(RUN_LEN)); // R6

    AST_DONE_CLEARS_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> (!busoff && $past(busoff) && cnt_clr)); // R7

    AST_LEC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_STAT && wr_data[LEC_W-1:0] == LEC_KEEP && !bit_strobe)
        |=> $stable(lec)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !rec_done); // R9

    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> !cnt_clr); // R9

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RECOVER && !bit_strobe) |=> ($stable(run_cnt) && $stable(occ_cnt))); // R11

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt < OCC_W'(IDLE_COUNT)); // R7

endmodule

bind boff_recovery_seq boff_recovery_chk #(
    .RUN_LEN   (RUN_LEN),
    .IDLE_COUNT(IDLE_COUNT),
    .RUN_W     (RUN_W),
    .OCC_W     (OCC_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_strobe   (bit_strobe),
    .busoff_evt   (busoff_evt),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .init_flag    (init_flag),
    .cfg_change_en(cfg_change_en),
    .bt_value     (bt_value),
    .lec          (lec),
    .busoff       (busoff),
    .rec_done     (rec_done),
    .cnt_clr      (cnt_clr),
    .phase        (phase),
    .run_cnt      (run_cnt),
    .occ_cnt      (occ_cnt)
);

// File: tb/tb_boff_recovery_seq.sv
// Directed bench for boff_recovery_seq: one task per scenario.
module tb_boff_recovery_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        rx_bit = 1'b1;
    logic        busoff_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic        init_flag, retx_off, cfg_change_en, test_mode;
    logic [31:0] bt_value;
    logic [2:0]  lec;
    logic        busoff, rec_done, cnt_clr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    boff_recovery_seq dut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
        .busoff_evt(busoff_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .init_flag(init_flag), .retx_off(retx_off),
        .cfg_change_en(cfg_change_en), .test_mode(test_mode),
        .bt_value(bt_value), .lec(lec), .busoff(busoff),
        .rec_done(rec_done), .cnt_clr(cnt_clr)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_busoff();
        @(negedge clk);
        busoff_evt = 1'b1;
        @(negedge clk);
        busoff_evt = 1'b0;
    endtask

    // One strobed bit; rx returns to recessive with strobe low to probe R11
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_strobe = 1'b1; rx_bit = b;
        @(negedge clk);
        bit_strobe = 1'b0; rx_bit = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 init", {31'd0, init_flag}, 32'd1);
        chk("R1 busoff", {31'd0, busoff}, 32'd0);
        chk("R1 lec", {29'd0, lec}, 32'd0);
        chk("R1 ctrl bits", {29'd0, retx_off, cfg_change_en, test_mode}, 32'd0);
        chk("R1 bt", bt_value, 32'h0000_2301);
        chk("R1 pulses", {30'd0, rec_done, cnt_clr}, 32'd0);
    endtask

    task automatic t_ctrl();
        reg_write(2'd0, 32'hFFFF_FFE1);
        chk("R2 all set", {28'd0, init_flag, retx_off, cfg_change_en, test_mode}, 32'hF);
        reg_write(2'd0, 32'hFFFF_FF21);
        chk("R2 dar only", {28'd0, init_flag, retx_off, cfg_change_en, test_mode}, 32'hC);
        reg_write(2'd0, 32'h0000_0001);
    endtask

    task automatic t_bt();
        reg_write(2'd2, 32'h0000_1234);
        chk("R3 locked cce=0", bt_value, 32'h0000_2301);
        reg_write(2'd0, 32'h0000_0041);
        reg_write(2'd2, 32'hFFFF_5A5A);
        chk("R3 open masked", bt_value, 32'h0000_5A5A);
        reg_write(2'd0, 32'h0000_0040);
        reg_write(2'd2, 32'h0000_1111);
        chk("R3 locked init=0", bt_value, 32'h0000_5A5A);
    endtask

    task automatic t_enter();
        reg_write(2'd0, 32'h0000_0000);
        reg_write(2'd1, 32'h0000_0002);
        chk("R8 lec write", {29'd0, lec}, 32'd2);
        chk("R4 pre", {30'd0, busoff, init_flag}, 32'd0);
        pulse_busoff();
        chk("R4 busoff+init", {30'd0, busoff, init_flag}, 32'd3);
        begin
            logic any_done = 1'b0;
            for (int i = 0; i < 30; i++) begin
                send_bit(1'b1);
                any_done |= rec_done;
            end
            chk("R5 lec held", {29'd0, lec}, 32'd2);
            chk("R5 no done", {31'd0, any_done}, 32'd0);
            chk("R5 still off", {30'd0, busoff, init_flag}, 32'd3);
        end
    endtask

    task automatic t_recover();
        logic early = 1'b0;
        reg_write(2'd0, 32'h0000_0000);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        chk("R6 run not complete", {29'd0, lec}, 32'd2);
        send_bit(1'b1);
        chk("R6 bit0 code", {29'd0, lec}, 32'h5);
        reg_write(2'd1, 32'h0000_0007);
        chk("R8 keep code", {29'd0, lec}, 32'h5);
        reg_write(2'd1, 32'h0000_0003);
        chk("R8 write 3", {29'd0, lec}, 32'd3);
        // Idle strobe-free cycles with rx high must not count
        repeat (40) @(negedge clk);
        chk("R11 no strobe", {29'd0, lec}, 32'd3);
        for (int i = 1; i <= 1408; i++) begin
            send_bit(1'b1);
            if (i == 11) chk("R6 second run", {29'd0, lec}, 32'h5);
            if (i < 1408) early |= rec_done | cnt_clr | ~busoff;
            if (i == 300) begin
                reg_write(2'd0, 32'h0000_0001);
                chk("R10 init set mid", {30'd0, busoff, init_flag}, 32'd3);
            end
            if (i == 310) begin
                pulse_busoff();
                chk("R12 retrigger", {30'd0, busoff, init_flag}, 32'd3);
            end
            if (i == 320) reg_write(2'd0, 32'h0000_0000);
            if (i == 1408) begin
                chk("R10 not early", {31'd0, early}, 32'd0);
                chk("R7 done+clr", {30'd0, rec_done, cnt_clr}, 32'd3);
                chk("R7 busoff off", {31'd0, busoff}, 32'd0);
            end
        end
        @(negedge clk);
        chk("R9 single pulse", {30'd0, rec_done, cnt_clr}, 32'd0);
    endtask

    task automatic t_again();
        pulse_busoff();
        chk("R4 second entry", {30'd0, busoff, init_flag}, 32'd3);
        chk("R9 no stray pulse", {30'd0, rec_done, cnt_clr}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_bt();
        t_enter();
        t_recover();
        t_again();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule